// File: doc/BRIEF.md
# Armed Pin-Change Event Detector

This block watches a group of digital input pins and turns level changes into event records for the host side. Each pin has its own 2-bit trigger selection: rising edge, falling edge, or any change. A pin produces an event only while it is armed. An armed pin that fires always disarms. From there it either stays disarmed until the host arms it again (single-shot), or it re-arms by itself once a hold-off interval has elapsed. The interval is counted in ticks of a prescaled timebase.

A build-time mask chooses which pins come out of reset already armed. The synchronized pin levels are available on a port at all times, whether or not any pin is armed. Events leave through a valid/ready handshake. Each record carries the pin index, the edge direction, a snapshot of all pin levels and a free-running cycle timestamp, all taken in the cycle the edge was detected. When several pins fire together, the lowest index goes out first and the rest wait.

Top module: `pin_event_arm`

## Requirements
- R1: Field `trig_mode_i[2i+1:2i]` selects the trigger for pin i: 2'b00 fires on a rising edge, 2'b01 on a falling edge, and 2'b10 or 2'b11 on either edge.
- R2: A pin whose `armed_o` bit is 0 produces no event for any transition.
- R3: With `rearm_auto_i[i]=0`, pin i disarms after it fires and stays disarmed until `arm_i[i]` is pulsed.
- R4: With `rearm_auto_i[i]=1`, pin i disarms after it fires. It re-arms on its own after `holdoff_i` ticks, where one tick occurs every `presc_i+1` clock cycles. Edges that arrive during the hold-off produce no event.
- R5: Pins set in parameter `BOOT_ARM` read as armed after reset with no command. Pin levels already present during reset produce no event.
- R6: `levels_o` equals `pins_i` delayed by two clock edges, independent of arming.
- R7: When several pins fire in the same cycle, the lowest pin index is offered first. Every other pin stays pending and is delivered once, in ascending order.
- R8: An event record holds `evt_pin_o`, `evt_rise_o` (1 for a rising edge, 0 for a falling edge), `evt_levels_o` and `evt_ts_o`, a clock-cycle counter value taken at detection. The record stays unchanged while `evt_valid_o` is 1 and `evt_ready_i` is 0.
- R9: `arm_i` on a pin that is already armed has no effect. `disarm_i` clears the armed state and any running hold-off, and it wins over `arm_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | N | Raw pin levels |
| trig_mode_i | input | 2*N | Per-pin trigger selection |
| rearm_auto_i | input | N | Per-pin hold-off re-arm enable |
| holdoff_i | input | HOLD_W | Hold-off length in ticks |
| presc_i | input | PRESC_W | Tick period minus one, in cycles |
| arm_i | input | N | Arm strobes |
| disarm_i | input | N | Disarm strobes |
| levels_o | output | N | Synchronized pin levels |
| armed_o | output | N | Per-pin armed state |
| evt_valid_o | output | 1 | Event record valid |
| evt_ready_i | input | 1 | Event record accepted |
| evt_pin_o | output | IDX_W | Pin index of the event |
| evt_rise_o | output | 1 | Edge direction, 1 = rising |
| evt_levels_o | output | N | Pin levels at detection |
| evt_ts_o | output | TS_W | Timestamp at detection |

## Verification
The assertions assume that arm and disarm strobes and configuration inputs change only between clock edges. They also assume that the consumer of the event port may hold ready low for any length of time. The pin inputs are treated as asynchronous, but the two-edge latency check needs them to hold steady across an edge. The stimulus changes every input shortly after a rising edge and samples every output at the falling edge. It keeps pin toggles a few cycles apart unless a test needs them to coincide.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_ANY  = 2'b10,
    TRIG_ANYX = 2'b11
  } trig_e;

  function automatic logic trig_match(input logic [1:0] mode, input logic rise, input logic fall);
    trig_e m;
    m = trig_e'(mode);
    case (m)
      TRIG_RISE: return rise;
      TRIG_FALL: return fall;
      default:   return rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/pev_sync_edge.sv
module pev_sync_edge #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;
  logic [1:0]   warm_q;
  logic         live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  // edges are masked until the pipeline holds only post-reset samples
  assign live   = (warm_q == 2'd3);
  assign lvl_o  = s2_q;
  assign rise_o = live ? (s2_q & ~prev_q) : '0;
  assign fall_o = live ? (~s2_q & prev_q) : '0;
endmodule

// File: rtl/pev_timebase.sv
module pev_timebase #(
  parameter int PRESC_W = 4,
  parameter int TS_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o,
  output logic [TS_W-1:0]    ts_o
);
  logic [PRESC_W-1:0] div_q;
  logic [TS_W-1:0]    ts_q;

  assign tick_o = (div_q >= presc_i);
  assign ts_o   = ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= tick_o ? '0 : div_q + 1'b1;
      ts_q  <= ts_q + 1'b1;
    end
  end
endmodule

// File: rtl/pev_pin_ctrl.sv
module pev_pin_ctrl
  import pin_event_pkg::*;
#(
  parameter int   N      = 8,
  parameter int   TS_W   = 16,
  parameter int   HOLD_W = 8,
  parameter logic BOOT   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [1:0]        mode_i,
  input  logic              auto_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              take_i,
  input  logic [N-1:0]      lvl_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              armed_o,
  output logic              pend_o,
  output logic              hit_o,
  output logic              rec_rise_o,
  output logic [N-1:0]      rec_lvl_o,
  output logic [TS_W-1:0]   rec_ts_o
);
  logic              armed_q, hold_q, pend_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              match;

  assign match = trig_match(mode_i, rise_i, fall_i);
  // an armed pin with an undelivered record drops further edges
  assign hit_o   = armed_q & ~pend_q & ~disarm_i & match;
  assign armed_o = armed_q;
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= BOOT;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (hit_o) begin
      armed_q <= 1'b0;
      hold_q  <= auto_i;
      cnt_q   <= holdoff_i;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      hold_q  <= 1'b0;
    end else if (hold_q) begin
      if (cnt_q == '0) begin
        armed_q <= 1'b1;
        hold_q  <= 1'b0;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      rec_rise_o <= 1'b0;
      rec_lvl_o  <= '0;
      rec_ts_o   <= '0;
    end else if (hit_o) begin
      pend_q     <= 1'b1;
      rec_rise_o <= rise_i;
      rec_lvl_o  <= lvl_i;
      rec_ts_o   <= ts_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pev_arbiter.sv
module pev_arbiter #(
  parameter int N     = 8,
  parameter int TS_W  = 16,
  parameter int IDX_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             pend_i,
  input  logic [N-1:0]             rec_rise_i,
  input  logic [N-1:0][N-1:0]      rec_lvl_i,
  input  logic [N-1:0][TS_W-1:0]   rec_ts_i,
  input  logic                     ready_i,
  output logic [N-1:0]             take_o,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         pin_o,
  output logic                     rise_o,
  output logic [N-1:0]             lvl_o,
  output logic [TS_W-1:0]          ts_o
);
  logic [IDX_W-1:0] sel;
  logic             load;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) sel = IDX_W'(i);
    end
  end

  assign load = (pend_i != '0) && (!valid_o || ready_i);

  always_comb begin
    take_o = '0;
    if (load) take_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pin_o   <= '0;
      rise_o  <= 1'b0;
      lvl_o   <= '0;
      ts_o    <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      pin_o   <= sel;
      rise_o  <= rec_rise_i[sel];
      lvl_o   <= rec_lvl_i[sel];
      ts_o    <= rec_ts_i[sel];
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_event_arm.sv
module pin_event_arm #(
  parameter int           N        = 8,
  parameter int           TS_W     = 16,
  parameter int           HOLD_W   = 8,
  parameter int           PRESC_W  = 4,
  parameter logic [N-1:0] BOOT_ARM = 8'h81,
  localparam int          IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       pins_i,
  input  logic [2*N-1:0]     trig_mode_i,
  input  logic [N-1:0]       rearm_auto_i,
  input  logic [HOLD_W-1:0]  holdoff_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [N-1:0]       arm_i,
  input  logic [N-1:0]       disarm_i,
  output logic [N-1:0]       levels_o,
  output logic [N-1:0]       armed_o,
  output logic               evt_valid_o,
  input  logic               evt_ready_i,
  output logic [IDX_W-1:0]   evt_pin_o,
  output logic               evt_rise_o,
  output logic [N-1:0]       evt_levels_o,
  output logic [TS_W-1:0]    evt_ts_o
);
  logic [N-1:0]           lvl_w, rise_w, fall_w;
  logic [N-1:0]           pend_w, hit_w, take_w, rec_rise_w;
  logic [N-1:0][N-1:0]    rec_lvl_w;
  logic [N-1:0][TS_W-1:0] rec_ts_w;
  logic                   tick_w;
  logic [TS_W-1:0]        ts_w;

  pev_sync_edge #(.N(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  pev_timebase #(.PRESC_W(PRESC_W), .TS_W(TS_W)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .presc_i (presc_i),
    .tick_o  (tick_w),
    .ts_o    (ts_w)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    pev_pin_ctrl #(
      .N(N), .TS_W(TS_W), .HOLD_W(HOLD_W), .BOOT(BOOT_ARM[g])
    ) u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise_w[g]),
      .fall_i     (fall_w[g]),
      .mode_i     (trig_mode_i[2*g +: 2]),
      .auto_i     (rearm_auto_i[g]),
      .holdoff_i  (holdoff_i),
      .tick_i     (tick_w),
      .arm_i      (arm_i[g]),
      .disarm_i   (disarm_i[g]),
      .take_i     (take_w[g]),
      .lvl_i      (lvl_w),
      .ts_i       (ts_w),
      .armed_o    (armed_o[g]),
      .pend_o     (pend_w[g]),
      .hit_o      (hit_w[g]),
      .rec_rise_o (rec_rise_w[g]),
      .rec_lvl_o  (rec_lvl_w[g]),
      .rec_ts_o   (rec_ts_w[g])
    );
  end

  pev_arbiter #(.N(N), .TS_W(TS_W), .IDX_W(IDX_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend_w),
    .rec_rise_i (rec_rise_w),
    .rec_lvl_i  (rec_lvl_w),
    .rec_ts_i   (rec_ts_w),
    .ready_i    (evt_ready_i),
    .take_o     (take_w),
    .valid_o    (evt_valid_o),
    .pin_o      (evt_pin_o),
    .rise_o     (evt_rise_o),
    .lvl_o      (evt_levels_o),
    .ts_o       (evt_ts_o)
  );

  assign levels_o = lvl_w;
endmodule

// File: rtl/pin_event_arm_chk.sv
module pin_event_arm_chk #(
  parameter int N     = 8,
  parameter int TS_W  = 16,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     pins_i,
  input logic [N-1:0]     disarm_i,
  input logic [N-1:0]     armed_o,
  input logic [N-1:0]     levels_o,
  input logic [N-1:0]     hit_w,
  input logic             evt_valid_o,
  input logic             evt_ready_i,
  input logic [IDX_W-1:0] evt_pin_o,
  input logic             evt_rise_o,
  input logic [N-1:0]     evt_levels_o,
  input logic [TS_W-1:0]  evt_ts_o
);
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  assert_rec_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_pin_o) &&
      $stable(evt_rise_o) && $stable(evt_levels_o) && $stable(evt_ts_o)));

  assert_disarm_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i != '0) |=> ((armed_o & $past(disarm_i)) == '0));

  assert_fire_disarms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w != '0) |=> ((armed_o & $past(hit_w)) == '0));

  assert_sync_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd3) |-> (levels_o == $past(pins_i, 2)));
endmodule

bind pin_event_arm pin_event_arm_chk #(.N(N), .TS_W(TS_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pins_i       (pins_i),
  .disarm_i     (disarm_i),
  .armed_o      (armed_o),
  .levels_o     (levels_o),
  .hit_w        (hit_w),
  .evt_valid_o  (evt_valid_o),
  .evt_ready_i  (evt_ready_i),
  .evt_pin_o    (evt_pin_o),
  .evt_rise_o   (evt_rise_o),
  .evt_levels_o (evt_levels_o),
  .evt_ts_o     (evt_ts_o)
);

// File: tb/pin_event_arm_tb.sv
`timescale 1ns/1ps
module pin_event_arm_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pins_r = 8'h80;
  logic [15:0] mode_r = '0;
  logic [7:0]  auto_r = '0;
  logic [7:0]  hold_r = '0;
  logic [3:0]  presc_r = '0;
  logic [7:0]  arm_r = '0;
  logic [7:0]  disarm_r = '0;
  logic        ready_r = 1'b1;
  logic [7:0]  levels_o, armed_o, evt_levels_o;
  logic        evt_valid_o, evt_rise_o;
  logic [2:0]  evt_pin_o;
  logic [15:0] evt_ts_o;

  always #10 clk = ~clk;

  pin_event_arm u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins_r), .trig_mode_i(mode_r),
    .rearm_auto_i(auto_r), .holdoff_i(hold_r), .presc_i(presc_r),
    .arm_i(arm_r), .disarm_i(disarm_r), .levels_o(levels_o), .armed_o(armed_o),
    .evt_valid_o(evt_valid_o), .evt_ready_i(ready_r), .evt_pin_o(evt_pin_o),
    .evt_rise_o(evt_rise_o), .evt_levels_o(evt_levels_o), .evt_ts_o(evt_ts_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  int          ev_n = 0;
  logic [2:0]  ev_pin [64];
  logic        ev_rise[64];
  logic [7:0]  ev_lvl [64];
  logic [15:0] ev_ts  [64];

  always @(negedge clk) begin
    if (rst_ni && evt_valid_o && ready_r && ev_n < 64) begin
      ev_pin[ev_n]  = evt_pin_o;
      ev_rise[ev_n] = evt_rise_o;
      ev_lvl[ev_n]  = evt_levels_o;
      ev_ts[ev_n]   = evt_ts_o;
      ev_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulse_arm(input logic [7:0] m);
    arm_r = m; step(); arm_r = '0;
  endtask

  task automatic pulse_disarm(input logic [7:0] m);
    disarm_r = m; step(); disarm_r = '0;
  endtask

  // pin, mode, arm first, new level, event expected, rising expected
  typedef struct packed {
    logic [2:0] pin;
    logic [1:0] mode;
    logic       arm;
    logic       lvl;
    logic       exp;
    logic       rise;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{3'd1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd2, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd2, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd3, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd4, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd5, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd5, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [15:0] ts0;
    steps(3);
    rst_ni = 1'b1;
    steps(10);

    // R5: boot mask armed, high level at reset gives no event
    chk(armed_o == 8'h81, "R5 boot armed", armed_o, 8'h81);
    chk(ev_n == 0, "R5 no event from reset level", ev_n, 0);
    chk(levels_o == 8'h80, "R6 levels after reset", levels_o, 8'h80);

    // R1/R2/R3 table
    for (int v = 0; v < 8; v++) begin
      vec_t e;
      e = VEC[v];
      mode_r[2*e.pin +: 2] = e.mode;
      if (e.arm) pulse_arm(8'(1) << e.pin);
      n0 = ev_n;
      pins_r[e.pin] = e.lvl;
      steps(8);
      chk((ev_n - n0) == int'(e.exp), "R1/R2 event count", ev_n - n0, e.exp);
      if (e.exp && ev_n > n0) begin
        chk(ev_pin[n0] == e.pin, "R8 event pin", ev_pin[n0], e.pin);
        chk(ev_rise[n0] == e.rise, "R1 edge type", ev_rise[n0], e.rise);
      end
      chk(levels_o == pins_r, "R6 levels follow pins", levels_o, pins_r);
    end
    chk(armed_o[1] == 1'b0, "R3 pin1 single-shot disarmed", armed_o[1], 0);
    chk(armed_o[3] == 1'b0, "R3 pin3 single-shot disarmed", armed_o[3], 0);

    // R8 timestamp and snapshot: pin0 then pin3 seven cycles later
    mode_r[7:6] = 2'b10;
    pulse_arm(8'h08);
    steps(2);
    n0 = ev_n;
    pins_r[0] = 1'b1;
    steps(7);
    pins_r[3] = 1'b1;
    steps(10);
    chk(ev_n - n0 == 2, "R8 two events", ev_n - n0, 2);
    if (ev_n - n0 == 2) begin
      chk(ev_pin[n0] == 3'd0 && ev_pin[n0+1] == 3'd3, "R8 pin order", ev_pin[n0+1], 3);
      chk(ev_ts[n0+1] - ev_ts[n0] == 16'd7, "R8 timestamp delta", ev_ts[n0+1] - ev_ts[n0], 7);
      chk((ev_lvl[n0+1] & 8'h89) == 8'h89, "R8 level snapshot", ev_lvl[n0+1], 8'h89);
    end

    // R7 simultaneous fire, consumer stalled
    mode_r[5:4] = 2'b10;
    mode_r[13:12] = 2'b10;
    pulse_arm(8'h44);
    ready_r = 1'b0;
    n0 = ev_n;
    pins_r[2] = 1'b1;
    pins_r[6] = 1'b1;
    steps(8);
    chk(evt_valid_o == 1'b1 && evt_pin_o == 3'd2, "R7 lowest first", evt_pin_o, 2);
    ts0 = evt_ts_o;
    steps(4);
    chk(evt_pin_o == 3'd2 && evt_ts_o == ts0 && evt_valid_o, "R8 record held", evt_ts_o, ts0);
    ready_r = 1'b1;
    steps(6);
    chk(ev_n - n0 == 2, "R7 both delivered once", ev_n - n0, 2);
    if (ev_n - n0 == 2)
      chk(ev_pin[n0] == 3'd2 && ev_pin[n0+1] == 3'd6, "R7 order", ev_pin[n0+1], 6);

    // R4 hold-off re-arm: tick every 4 cycles, 5 ticks
    mode_r[9:8] = 2'b10;
    auto_r[4] = 1'b1;
    presc_r = 4'd3;
    hold_r = 8'd5;
    pulse_arm(8'h10);
    n0 = ev_n;
    pins_r[4] = 1'b0;
    steps(6);
    chk(ev_n - n0 == 1, "R4 first event", ev_n - n0, 1);
    steps(4);
    chk(armed_o[4] == 1'b0, "R4 disarmed in hold-off", armed_o[4], 0);
    pins_r[4] = 1'b1;
    steps(8);
    chk(ev_n - n0 == 1, "R4 edge in hold-off dropped", ev_n - n0, 1);
    steps(30);
    chk(armed_o[4] == 1'b1, "R4 re-armed", armed_o[4], 1);
    chk(ev_n - n0 == 1, "R4 no event on re-arm", ev_n - n0, 1);
    pins_r[4] = 1'b0;
    steps(8);
    chk(ev_n - n0 == 2, "R4 event after re-arm", ev_n - n0, 2);

    // R9 disarm during hold-off cancels re-arm
    steps(1);
    pulse_disarm(8'h10);
    steps(40);
    chk(armed_o[4] == 1'b0, "R9 disarm clears hold-off", armed_o[4], 0);

    // R9 arm on armed pin7 has no effect
    n0 = ev_n;
    pulse_arm(8'h80);
    steps(4);
    chk(armed_o[7] == 1'b1 && ev_n == n0, "R9 re-arm no effect", armed_o[7], 1);

    // R9 arm and disarm together: disarm wins
    arm_r = 8'h02; disarm_r = 8'h02;
    step();
    arm_r = '0; disarm_r = '0;
    steps(2);
    chk(armed_o[1] == 1'b0, "R9 disarm wins", armed_o[1], 0);

    // R2 disarmed pin7 ignores a falling edge in any-change mode
    mode_r[15:14] = 2'b10;
    pulse_disarm(8'h80);
    n0 = ev_n;
    pins_r[7] = 1'b0;
    steps(8);
    chk(ev_n == n0, "R2 disarmed pin ignored", ev_n - n0, 0);
    chk(levels_o[7] == 1'b0, "R6 level of unarmed pin", levels_o[7], 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule